// File: doc/BRIEF.md
# Microsequencer with Host Maintenance Control

This block is a small microcoded sequencer whose instruction fetch can be steered by a host for diagnosis. A 256-word, 16-bit control store is filled through a write port. A program counter walks the store. Each fetch/execute cycle either falls through to the next address or branches to an 8-bit target. Only two instruction kinds do anything: a conditional branch and a test-point set/clear. Every other word behaves as a no-operation.

The host has direct control lines. `run` lets the sequencer execute freely. `step_mode` with `step_req` pulses advances it by exactly one instruction at a time. `br_dis` forces every branch to fall through, so the store can be read out in address order. A maintenance data register serves two purposes, chosen by `inj_sel`. With the select clear, the register returns the control word fetched most recently. With the select set, a host write loads a word that the next cycle executes in place of the store word. Each such loaded word executes once. The two test-point flags can be read back, so a diagnostic program can confirm that set/clear instructions really change them.

Top module: `useq_maint_ctl`

## Requirements
- R1: With `step_mode` low, the sequencer executes one instruction on every clock while `run` is high, and holds its program counter, test points and data register while `run` is low.
- R2: With `step_mode` high, `run` has no effect. Each clock with `step_req` high executes exactly one instruction, and clocks with `step_req` low change nothing.
- R3: While `br_dis` is high, every executed instruction sets the program counter to the old value plus one (modulo 256), whether or not a branch condition holds.
- R4: A word with bits [14:10] all zero is a branch. Bits [9:8] select its test: 00 never, 01 always, 10 test point 0, 11 test point 1. When the test is true the program counter loads bits [7:0]; otherwise it increments. Bit 15 is ignored.
- R5: With `inj_sel` low, `sdr_rdata` shows the control-store word fetched by the last instruction taken from the store. It is zero after reset.
- R6: A write on `sdr_we` with `inj_sel` high captures `sdr_wdata`, and `sdr_rdata` shows it while `inj_sel` is high. The next executed instruction uses that word instead of the store word. Later instructions come from the store again.
- R7: A write on `sdr_we` with `inj_sel` low has no effect on `sdr_rdata` or on which word executes next.
- R8: A word with bits [14:12] = 001 is set/clear. Bit 11 is written into the test point addressed by bit 0, and `br_true[1:0]` shows test points 1 and 0.
- R9: Reset clears the program counter, both test points and the data register.
- R10: A write on the control-store port stores `cs_wdata` at `cs_waddr`, and the next fetch from that address uses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_we | input | 1 | Control-store write strobe |
| cs_waddr | input | 8 | Control-store write address |
| cs_wdata | input | 16 | Control-store write data |
| run | input | 1 | Free-run enable |
| step_mode | input | 1 | Single-step mode |
| step_req | input | 1 | One-instruction step request |
| br_dis | input | 1 | Force branches to fall through |
| inj_sel | input | 1 | Data register source: 0 read fetched word, 1 inject |
| sdr_we | input | 1 | Data register write strobe |
| sdr_wdata | input | 16 | Data register write data |
| sdr_rdata | output | 16 | Data register read value |
| pc | output | 8 | Program counter |
| br_true | output | 2 | Test-point flags {tp1, tp0} |

## Verification
A wrong program counter shows on `pc` at the next sampling point after the faulty clock. It then usually makes the fetched word visible on `sdr_rdata` diverge one instruction later. A stuck or miscleared injection flag makes a second instruction execute the injected word. That shows up as a program-counter jump within one step. Test-point errors appear on `br_true` right away, and they change later conditional branches, so the effect compounds over a few instructions.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 8;
  localparam int TP_N   = 2;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;

  // branch class: upper opcode bits [14:10] zero
  function automatic logic is_branch(word_t w);
    return w[14:10] == 5'b00000;
  endfunction

  // set/clear class: bits [14:12] == 001
  function automatic logic is_setclr(word_t w);
    return w[14:12] == 3'b001;
  endfunction

  function automatic logic test_hit(word_t w, logic [TP_N-1:0] tp);
    case (w[9:8])
      2'b00:   return 1'b0;
      2'b01:   return 1'b1;
      2'b10:   return tp[0];
      default: return tp[1];
    endcase
  endfunction

  function automatic addr_t next_addr(word_t w, addr_t cur, logic tp_hit, logic nobr);
    if (is_branch(w) && tp_hit && !nobr) return w[ADDR_W-1:0];
    return cur + addr_t'(1);
  endfunction
endpackage

// File: rtl/useq_cstore.sv
module useq_cstore #(
  parameter int AW = useq_pkg::ADDR_W,
  parameter int DW = useq_pkg::WORD_W
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/useq_testpt.sv
module useq_testpt #(
  parameter int NTP = useq_pkg::TP_N
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    exec,
  input  useq_pkg::word_t         word,
  output logic [NTP-1:0]          tp
);
  import useq_pkg::*;
  localparam int IW = (NTP > 1) ? $clog2(NTP) : 1;

  logic          sc_fire;
  logic [IW-1:0] sc_idx;
  assign sc_fire = exec && is_setclr(word);
  assign sc_idx  = word[IW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) tp <= '0;
    else if (sc_fire) tp[sc_idx] <= word[11];
  end

  p_tp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sc_fire |=> $stable(tp));
  p_tp_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sc_fire |=> tp[$past(sc_idx)] == $past(word[11]));
endmodule

// File: rtl/useq_seq.sv
module useq_seq #(
  parameter int AW  = useq_pkg::ADDR_W,
  parameter int DW  = useq_pkg::WORD_W,
  parameter int NTP = useq_pkg::TP_N
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           step_mode,
  input  logic           step_req,
  input  logic           br_dis,
  input  logic           inj_sel,
  input  logic           sdr_we,
  input  logic [DW-1:0]  sdr_wdata,
  input  logic [DW-1:0]  cs_word,
  input  logic [NTP-1:0] tp,
  output logic [AW-1:0]  pc,
  output logic [DW-1:0]  exec_word,
  output logic           exec,
  output logic [DW-1:0]  sdr_rdata
);
  import useq_pkg::*;

  logic [DW-1:0] last_cs_q;
  logic [DW-1:0] inj_q;
  logic          inj_pend_q;
  logic          inj_load;
  logic          hit;
  logic          br_always;
  logic [AW-1:0] pc_nxt;

  assign exec      = step_mode ? step_req : run;
  assign exec_word = inj_pend_q ? inj_q : cs_word;
  assign inj_load  = sdr_we && inj_sel;
  assign hit       = test_hit(exec_word, tp);
  assign br_always = is_branch(exec_word) && (exec_word[9:8] == 2'b01);
  assign pc_nxt    = next_addr(exec_word, pc, hit, br_dis);
  assign sdr_rdata = inj_sel ? inj_q : last_cs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc        <= '0;
      last_cs_q <= '0;
    end else if (exec) begin
      pc <= pc_nxt;
      if (!inj_pend_q) last_cs_q <= cs_word;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inj_q      <= '0;
      inj_pend_q <= 1'b0;
    end else if (inj_load) begin
      inj_q      <= sdr_wdata;
      inj_pend_q <= 1'b1;
    end else if (exec) begin
      inj_pend_q <= 1'b0;
    end
  end

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_mode && !run) |=> $stable(pc));
  p_step_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_mode && !step_req) |=> $stable(pc));
  p_seq_walk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && br_dis) |=> pc == $past(pc) + 1'b1);
  p_uncond_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && br_always && !br_dis) |=> pc == $past(exec_word[AW-1:0]));
  p_inj_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !inj_load) |=> !inj_pend_q);
  p_ign_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!inj_sel && !exec) |=> $stable(last_cs_q));
endmodule

// File: rtl/useq_maint_ctl.sv
module useq_maint_ctl #(
  parameter int AW  = useq_pkg::ADDR_W,
  parameter int DW  = useq_pkg::WORD_W,
  parameter int NTP = useq_pkg::TP_N
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_we,
  input  logic [AW-1:0]  cs_waddr,
  input  logic [DW-1:0]  cs_wdata,
  input  logic           run,
  input  logic           step_mode,
  input  logic           step_req,
  input  logic           br_dis,
  input  logic           inj_sel,
  input  logic           sdr_we,
  input  logic [DW-1:0]  sdr_wdata,
  output logic [DW-1:0]  sdr_rdata,
  output logic [AW-1:0]  pc,
  output logic [NTP-1:0] br_true
);
  logic [DW-1:0]  cs_word;
  logic [DW-1:0]  exec_word;
  logic           exec;
  logic [NTP-1:0] tp;

  useq_cstore #(.AW(AW), .DW(DW)) u_cstore (
    .clk(clk), .we(cs_we), .waddr(cs_waddr), .wdata(cs_wdata),
    .raddr(pc), .rdata(cs_word)
  );

  useq_seq #(.AW(AW), .DW(DW), .NTP(NTP)) u_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .step_mode(step_mode),
    .step_req(step_req), .br_dis(br_dis), .inj_sel(inj_sel),
    .sdr_we(sdr_we), .sdr_wdata(sdr_wdata), .cs_word(cs_word), .tp(tp),
    .pc(pc), .exec_word(exec_word), .exec(exec), .sdr_rdata(sdr_rdata)
  );

  useq_testpt #(.NTP(NTP)) u_testpt (
    .clk(clk), .rst_n(rst_n), .exec(exec), .word(exec_word), .tp(tp)
  );

  assign br_true = tp;

  p_reset_r9: assert property (@(posedge clk)
    !rst_n |=> (pc == '0) && (tp == '0));
endmodule

// File: tb/useq_maint_ctl_tb.sv
module useq_maint_ctl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_we = 0; logic [7:0] cs_waddr = 0; logic [15:0] cs_wdata = 0;
  logic run = 0, step_mode = 0, step_req = 0, br_dis = 0, inj_sel = 0, sdr_we = 0;
  logic [15:0] sdr_wdata = 0;
  logic [15:0] sdr_rdata;
  logic [7:0]  pc;
  logic [1:0]  br_true;

  always #10 clk = ~clk;

  useq_maint_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .cs_we(cs_we), .cs_waddr(cs_waddr),
    .cs_wdata(cs_wdata), .run(run), .step_mode(step_mode),
    .step_req(step_req), .br_dis(br_dis), .inj_sel(inj_sel),
    .sdr_we(sdr_we), .sdr_wdata(sdr_wdata), .sdr_rdata(sdr_rdata),
    .pc(pc), .br_true(br_true)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  logic [15:0] m_cs [256];
  logic [7:0]  m_pc;
  logic [1:0]  m_tp;
  logic [15:0] m_last, m_inj;
  bit          m_pend;

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  // reference: decode by masks, per the requirement encodings
  function automatic bit m_taken(logic [15:0] w, logic [1:0] t);
    if ((w & 16'h7C00) != 16'h0000) return 0;
    if (w[9:8] == 2'd0) return 0;
    if (w[9:8] == 2'd1) return 1;
    return t[w[9] & w[8]];
  endfunction

  task automatic model_edge();
    bit go;
    logic [15:0] w;
    if (!rst_n) begin
      m_pc = 0; m_tp = 0; m_last = 0; m_inj = 0; m_pend = 0;
    end else begin
      go = step_mode ? step_req : run;
      if (go) begin
        w = m_pend ? m_inj : m_cs[m_pc];
        if (!m_pend) m_last = m_cs[m_pc];
        if (!br_dis && m_taken(w, m_tp)) m_pc = w[7:0];
        else m_pc = m_pc + 8'd1;
        if ((w & 16'h7000) == 16'h1000) m_tp[w[0]] = w[11];
        m_pend = 0;
      end
      if (sdr_we && inj_sel) begin m_inj = sdr_wdata; m_pend = 1; end
    end
    if (cs_we) m_cs[cs_waddr] = cs_wdata;
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check("R4 pc", 32'(pc), 32'(m_pc));
    check("R8 br_true", 32'(br_true), 32'(m_tp));
    check("R5/R6 sdr_rdata", 32'(sdr_rdata), 32'(inj_sel ? m_inj : m_last));
  endtask

  task automatic cs_put(logic [7:0] a, logic [15:0] d);
    cs_we = 1; cs_waddr = a; cs_wdata = d;
    tick();
    cs_we = 0;
  endtask

  task automatic step1();
    step_req = 1; tick(); step_req = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    // R10: preload through the store port (during reset)
    for (int i = 0; i < 256; i++) cs_put(8'(i), 16'($urandom));
    cs_put(8'h00, 16'h0105);
    cs_put(8'h05, 16'h1801);
    cs_put(8'h06, 16'h0320);
    cs_put(8'h20, 16'h0000);
    rst_n = 1;
    tick();
    check("R9 reset pc", 32'(pc), 0);
    check("R9 reset tp", 32'(br_true), 0);
    check("R9 reset sdr", 32'(sdr_rdata), 0);
    repeat (3) tick();
    check("R1 hold", 32'(pc), 0);
    step_mode = 1; run = 1;
    repeat (2) tick();
    check("R2 idle step", 32'(pc), 0);
    step1();
    check("R2/R4 branch always", 32'(pc), 32'h05);
    check("R5 fetched word", 32'(sdr_rdata), 32'h0105);
    tick();
    check("R2 one per step", 32'(pc), 32'h05);
    step1();
    check("R8 set tp1", 32'(br_true), 32'h2);
    step1();
    check("R4 tp1 branch", 32'(pc), 32'h20);
    check("R10 stored word used", 32'(sdr_rdata), 32'h0320);
    br_dis = 1; inj_sel = 1; sdr_we = 1; sdr_wdata = 16'h8142;
    tick();
    sdr_we = 0;
    check("R6 inject readback", 32'(sdr_rdata), 32'h8142);
    step1();
    check("R3 branch disabled", 32'(pc), 32'h21);
    br_dis = 0; sdr_we = 1; sdr_wdata = 16'h8142;
    tick();
    sdr_we = 0;
    step1();
    check("R6 injected branch", 32'(pc), 32'h42);
    step1();
    check("R6 once", 32'(pc), 32'(m_taken(m_cs[8'h42], m_tp) ? m_cs[8'h42][7:0] : 8'h43));
    inj_sel = 0; sdr_we = 1; sdr_wdata = 16'h0199;
    tick();
    sdr_we = 0;
    check("R7 ignored write", 32'(sdr_rdata), 32'(m_cs[8'h42]));
    step_mode = 0; run = 1;
    repeat (20) tick();
    // mixed random phase
    for (int c = 0; c < 4000; c++) begin
      int r;
      r = $urandom_range(0, 99);
      run       = (r < 60);
      step_mode = ($urandom_range(0, 3) == 0);
      step_req  = $urandom_range(0, 1);
      br_dis    = ($urandom_range(0, 7) == 0);
      inj_sel   = ($urandom_range(0, 3) == 0);
      sdr_we    = ($urandom_range(0, 5) == 0);
      case ($urandom_range(0, 2))
        0: sdr_wdata = {1'($urandom), 5'b0, 2'($urandom), 8'($urandom)};
        1: sdr_wdata = {1'($urandom), 3'b001, 1'($urandom), 10'($urandom), 1'($urandom)};
        default: sdr_wdata = 16'($urandom);
      endcase
      cs_we = ($urandom_range(0, 9) == 0);
      cs_waddr = 8'($urandom);
      cs_wdata = {1'b0, 5'b0, 2'($urandom), 8'($urandom)};
      tick();
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule